// File: doc/BRIEF.md
# DMA Helper Control Register Bank

This block is the software-visible control face of a small DMA helper that sits beside a SCSI-style bus controller. It holds a bank of 32-bit word registers: one control/status word, one transfer address word and spare words. A host bus reads and writes them through a word-select address, a write strobe and write and read data. Address translation and the data movement itself happen elsewhere. This bank only keeps the pointer and the status bits, and raises the interrupt.

Writes to the control word do not land verbatim. A request bit sends a one-cycle reset pulse to the attached controller. A set acknowledge bit is dropped before the value is stored. A write of zero is replaced by a fixed default. The top nibble always reads back as a fixed version code. Loading the address word also overwrites the control word with a lone "address loaded" flag. The attached controller raises the pending-interrupt bit through a one-cycle strobe. The interrupt line is the AND of the pending and enable bits.

Top module: `dmacr_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears to zero, and `irq_o` and `ctl_reset_o` are low after that edge.
- R2: Byte address bits [3:2] select the register: 0 is control, 1 is transfer address, 2 and 3 are spare words. All other address bits are ignored for both reads and writes.
- R3: A control write with bit 7 set drives `ctl_reset_o` high for exactly the cycle after that write. Bit 7 and bit 6 are then stored unchanged, apart from the version nibble.
- R4: A control write with bit 7 clear and bit 6 set stores the value with bit 6 cleared.
- R5: A control write of exactly 0x00000000 stores 0xA0000040.
- R6: Every value stored by a control write has bits [31:28] equal to the version code 0xA, and bits [27:0] taken from the rewritten value.
- R7: A write to the address word stores the data there. In the same cycle it sets the control word to 0x04000000 (bit 26, address loaded), with no version nibble.
- R8: A one-cycle high on `ctl_irq_set_i` sets control bit 0 (interrupt pending) at that edge. All other control bits are left alone.
- R9: `irq_o` is high exactly when control bit 0 and control bit 4 (interrupt enable) are both set. A control write with bit 4 clear therefore leaves `irq_o` low from the next cycle on.
- R10: Reads return the selected register combinationally and change no state, so repeated reads return the same value.
- R11: When `ctl_irq_set_i` coincides with a control or address write, the written or forced control value is stored with bit 0 additionally set.
- R12: The spare words store the written data verbatim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte address; bits [3:2] pick the register |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Selected register contents |
| ctl_irq_set_i | input | 1 | One-cycle strobe from the controller setting interrupt pending |
| irq_o | output | 1 | Interrupt request (pending AND enable) |
| ctl_reset_o | output | 1 | One-cycle reset pulse to the attached controller |

## Verification
The two functions that can collide are a host write to the control or address word and the controller's pending-interrupt strobe, both of which update the control word at the same edge. The bench drives the strobe in the very cycle of a control write with enable set, of an address load, and of a zero write. It judges the result through the read-back value and `irq_o`, both of which must show bit 0 merged into the rewritten value, against a behavioural model advanced every clock.

// File: rtl/dmacr_pkg.sv
// Package: register format of the DMA helper control bank.
// Assumes a 32-bit control word; bit positions are fixed by the format.
package dmacr_pkg;
    localparam int PEND_BIT   = 0;   // interrupt pending
    localparam int IEN_BIT    = 4;   // interrupt enable
    localparam int ACK_BIT    = 6;   // dropped on write
    localparam int RST_BIT    = 7;   // controller reset request
    localparam int LOADED_BIT = 26;  // address word was loaded
    localparam int VER_W      = 4;   // width of version nibble

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_SPARE0 = 2'd2,
        SEL_SPARE1 = 2'd3
    } dmacr_sel_e;
endpackage

// File: rtl/dmacr_ctrl_rewrite.sv
// Module: rewrites a host value bound for the control word.
// Reset request wins over acknowledge-drop, which wins over zero substitution;
// the top nibble is then replaced by the version code. Purely combinational.
module dmacr_ctrl_rewrite
    import dmacr_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [VER_W-1:0]  VERSION  = 4'hA,
    parameter logic [DATA_W-1:0] ZERO_SUB = 32'h0000_0040
) (
    input  logic [DATA_W-1:0] raw_i,
    output logic [DATA_W-1:0] stored_o,
    output logic              rst_req_o
);
    localparam int LOW_W = DATA_W - VER_W;

    logic [DATA_W-1:0] val;

    // Apply the prioritised rewrite rules and stamp the version.
    always_comb begin
        val       = raw_i;
        rst_req_o = 1'b0;
        if (raw_i[RST_BIT]) begin
            rst_req_o = 1'b1;
        end else if (raw_i[ACK_BIT]) begin
            val[ACK_BIT] = 1'b0;
        end else if (raw_i == '0) begin
            val = ZERO_SUB;
        end
        stored_o = {VERSION, val[LOW_W-1:0]};
    end
endmodule

// File: rtl/dmacr_regs.sv
// Module: storage for the control, address and spare words.
// Assumes at most one bit of we_i is set; ctrl_val_i is the rewritten control value.
// The pending-set strobe is merged into the control word after any write.
module dmacr_regs
    import dmacr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              we_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic [DATA_W-1:0]                ctrl_val_i,
    input  logic                             pend_set_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  words_o
);
    localparam logic [DATA_W-1:0] LOADED_VAL = DATA_W'(1) << LOADED_BIT;

    logic [DATA_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] addr_q;

    // Next control value: host write, address-load override, then pending set.
    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i[SEL_CTRL]) begin
            ctrl_d = ctrl_val_i;
        end else if (we_i[SEL_ADDR]) begin
            ctrl_d = LOADED_VAL;
        end
        if (pend_set_i) begin
            ctrl_d[PEND_BIT] = 1'b1;
        end
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Transfer address register.
    always_ff @(posedge clk) begin
        if (!rst_n)              addr_q <= '0;
        else if (we_i[SEL_ADDR]) addr_q <= wdata_i;
    end

    assign words_o[SEL_CTRL] = ctrl_q;
    assign words_o[SEL_ADDR] = addr_q;

    // Spare words: plain storage, one register per remaining index.
    for (genvar k = 2; k < NUM_REGS; k++) begin : g_spare
        logic [DATA_W-1:0] q;
        // Hold the spare word, loaded verbatim on its write.
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (we_i[k]) q <= wdata_i;
        end
        assign words_o[k] = q;
    end
endmodule

// File: rtl/dmacr_bank.sv
// Module: top of the DMA helper control register bank.
// Decodes the host access, routes control writes through the rewrite logic,
// forms the interrupt and registers the one-cycle controller reset pulse.
// Assumes a synchronous host bus with a single-cycle write strobe.
module dmacr_bank
    import dmacr_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter int                NUM_REGS = 4,
    parameter logic [VER_W-1:0]  VERSION  = 4'hA,
    parameter logic [DATA_W-1:0] ZERO_SUB = 32'h0000_0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              ctl_irq_set_i,
    output logic              irq_o,
    output logic              ctl_reset_o
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [DATA_W-1:0] LOADED_VAL = DATA_W'(1) << LOADED_BIT;

    logic [IDX_W-1:0]                 sel;
    logic [NUM_REGS-1:0]              we_vec;
    logic [DATA_W-1:0]                ctrl_val;
    logic                             rst_req;
    logic [NUM_REGS-1:0][DATA_W-1:0]  words;

    assign sel = addr_i[IDX_W+1:2];

    // One-hot write enable for the selected word.
    always_comb begin
        we_vec = '0;
        if (wr_en_i) we_vec[sel] = 1'b1;
    end

    dmacr_ctrl_rewrite #(
        .DATA_W   (DATA_W),
        .VERSION  (VERSION),
        .ZERO_SUB (ZERO_SUB)
    ) u_rewrite (
        .raw_i     (wdata_i),
        .stored_o  (ctrl_val),
        .rst_req_o (rst_req)
    );

    dmacr_regs #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (we_vec),
        .wdata_i    (wdata_i),
        .ctrl_val_i (ctrl_val),
        .pend_set_i (ctl_irq_set_i),
        .words_o    (words)
    );

    // Side-effect-free read of the selected word.
    assign rdata_o = words[sel];

    // Interrupt: pending and enabled.
    assign irq_o = words[SEL_CTRL][PEND_BIT] & words[SEL_CTRL][IEN_BIT];

    // Register the controller reset pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_reset_o <= 1'b0;
        else        ctl_reset_o <= we_vec[SEL_CTRL] & rst_req;
    end

    // R3: reset request produces the pulse in the next cycle.
    assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_vec[SEL_CTRL] && wdata_i[RST_BIT]) |=> ctl_reset_o);

    // R3: no request, no pulse.
    assert_no_spurious_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_vec[SEL_CTRL] && wdata_i[RST_BIT]) |=> !ctl_reset_o);

    // R6: stored control writes carry the version code.
    assert_version_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_vec[SEL_CTRL] |=> (words[SEL_CTRL][DATA_W-1 -: VER_W] == VERSION));

    // R7: address load forces the loaded flag and keeps the address.
    assert_addr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_vec[SEL_ADDR] && !ctl_irq_set_i) |=>
        (words[SEL_CTRL] == LOADED_VAL && words[SEL_ADDR] == $past(wdata_i)));

    // R8: pending strobe always lands in bit 0.
    assert_pend_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_irq_set_i |=> words[SEL_CTRL][PEND_BIT]);

    // R9: writing with enable clear silences the interrupt.
    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_vec[SEL_CTRL] && !wdata_i[IEN_BIT]) |=> !irq_o);
endmodule

// File: tb/dmacr_bank_test.sv
`timescale 1ns/1ps
// Bench: drives host accesses and the pending strobe, advances a behavioural
// model each clock, compares read data, interrupt and reset pulse every cycle.
module dmacr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic        set_s = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    logic        crst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_reg [4];
    logic        m_rst;

    always #10 clk = ~clk;

    dmacr_bank uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_i        (addr),
        .wr_en_i       (wr_en),
        .wdata_i       (wdata),
        .rdata_o       (rdata),
        .ctl_irq_set_i (set_s),
        .irq_o         (irq),
        .ctl_reset_o   (crst)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model of one clock edge, written from the requirements.
    task automatic model_edge(input logic rn, input logic w, input logic [7:0] a,
                              input logic [31:0] d, input logic s);
        logic [31:0] v;
        int idx;
        idx = int'(a[3:2]);
        if (!rn) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 32'h0;
            m_rst = 1'b0;
            return;
        end
        m_rst = 1'b0;
        if (w) begin
            if (idx == 0) begin
                v = d;
                if (d[7]) m_rst = 1'b1;
                else if (d[6]) v[6] = 1'b0;
                else if (d == 32'h0) v = 32'h40;
                m_reg[0] = (v & 32'h0FFF_FFFF) | 32'hA000_0000;
            end else if (idx == 1) begin
                m_reg[1] = d;
                m_reg[0] = 32'h0400_0000;
            end else begin
                m_reg[idx] = d;
            end
        end
        if (s) m_reg[0][0] = 1'b1;
    endtask

    task automatic compare(input string req);
        check(req, "rdata", rdata, m_reg[int'(addr[3:2])]);
        check(req, "irq", {31'h0, irq}, {31'h0, m_reg[0][0] & m_reg[0][4]});
        check(req, "ctl_reset", {31'h0, crst}, {31'h0, m_rst});
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic s, input string req);
        wr_en = w; addr = a; wdata = d; set_s = s;
        @(posedge clk);
        model_edge(rst_n, w, a, d, s);
        @(negedge clk);
        compare(req);
        wr_en = 1'b0; set_s = 1'b0;
    endtask

    task automatic reset_step(input string req);
        rst_n = 1'b0;
        step(1'b1, 8'h00, 32'h0000_0011, 1'b1, req);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = 32'h0;
        m_rst = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reset_step("R1");
        step(0, 8'h00, 0, 0, "R1");
        step(0, 8'h04, 0, 0, "R1");
        step(0, 8'h08, 0, 0, "R1");
        step(0, 8'h0C, 0, 0, "R1");
        // Address load forces the loaded flag.
        step(1, 8'h04, 32'h1234_5678, 0, "R7");
        step(0, 8'h00, 0, 0, "R7");
        // Spare words verbatim.
        step(1, 8'h08, 32'hDEAD_BEEF, 0, "R12");
        step(1, 8'h0C, 32'h0BAD_F00D, 0, "R12");
        step(0, 8'h08, 0, 0, "R12");
        // Aliased addresses hit the same word.
        step(1, 8'hF8, 32'h0000_0055, 0, "R2");
        step(0, 8'h48, 0, 0, "R2");
        step(0, 8'hB4, 0, 0, "R2");
        // Control rewrites.
        step(1, 8'h00, 32'h0000_0000, 0, "R5");
        step(1, 8'h00, 32'h5000_0000, 0, "R6");
        step(1, 8'h70, 32'h1234_5611, 0, "R9");
        step(1, 8'h00, 32'h0000_0050, 0, "R4");
        step(1, 8'h00, 32'hF000_0070, 0, "R4");
        // Pending strobe alone, then disable.
        step(1, 8'h00, 32'h0000_0010, 0, "R9");
        step(0, 8'h00, 0, 1, "R8");
        step(0, 8'h04, 0, 0, "R8");
        step(1, 8'h00, 32'h0000_0001, 0, "R9");
        // Controller reset request.
        step(1, 8'h00, 32'h0000_00C0, 0, "R3");
        step(0, 8'h00, 0, 0, "R3");
        step(1, 8'h00, 32'h0000_00D1, 0, "R3");
        step(1, 8'h00, 32'h0000_0080, 0, "R3");
        step(0, 8'h00, 0, 0, "R3");
        // Reads have no side effects.
        step(0, 8'h00, 0, 0, "R10");
        step(0, 8'h00, 0, 0, "R10");
        step(0, 8'h0C, 0, 0, "R10");
        // Coinciding strobe and writes.
        step(1, 8'h00, 32'h0000_0010, 1, "R11");
        step(1, 8'h04, 32'hCAFE_0000, 1, "R11");
        step(0, 8'h00, 0, 0, "R11");
        step(1, 8'h00, 32'h0000_0000, 1, "R11");
        step(1, 8'h00, 32'h0000_0050, 1, "R11");
        // Reset mid-run wins over write and strobe.
        reset_step("R1");
        step(0, 8'h04, 0, 0, "R1");
        step(0, 8'h08, 0, 0, "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule